// File: doc/BRIEF.md
# Platform System Control Register Block

This block sits on a byte-wide, ISA-style I/O bus and answers a small group of platform control and identification ports. A 16-bit port address is qualified by separate read and write strobes. Some ports return fixed identification bytes. Some hold control fields that software can write and read back. Writing to the remaining ports produces single-cycle request pulses toward logic outside the block: a soft reset request, two lock toggles for non-volatile memory, and a cache invalidate request.

The stored map-mode bit and a drive-activity indicator bit leave the block as level outputs. Two independent scratch bytes give firmware a place to store values. A read of any port that is not decoded returns 0xFF. A write to a port that accepts no writes raises a one-cycle error strobe and changes nothing. The reset sequencer, the cache and the non-volatile memory are outside the block. It only drives the request lines toward them.

Top module: `plat_ctl_regs`

## Requirements
- R1: After reset every stored field (control nibble, map bit, drive indicator, both scratch bytes) is 0, read data is 0x00 and every pulse and strobe output is low.
- R2: Read data is registered. The value of the addressed port appears on io_rdata one clock after the edge that samples io_rd, and holds while io_rd is low.
- R3: Port 0x0092 reads 0x00. A write to it with data bit 0 set pulses soft_rst_req for one cycle. A write with data bit 1 set pulses endian_err for one cycle.
- R4: Identification ports read fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39. Writes to 0x0800, 0x0802 and 0x0803 are accepted silently: no state change and no error strobe.
- R5: A write to port 0x0808 sets drive_led to data bit 0.
- R6: Every write to 0x0810 pulses nv_lock1_tgl for one cycle, and every write to 0x0812 pulses nv_lock2_tgl for one cycle, whatever the data.
- R7: Port 0x081C stores data bits 3:0 of a write and reads back as {4'b0, stored nibble}.
- R8: Port 0x0850 stores data bit 0 as the map mode (0 contiguous, 1 non-contiguous). It drives map_noncontig and reads back as {7'b0, bit}.
- R9: Port 0x0818 reads 0x00 and port 0x0823 reads 0x03. A write to 0x0814 pulses cache_inval for one cycle, and a read of 0x0814 returns 0xFF.
- R10: A read of any port not listed in R3 to R9 or R12 returns 0xFF.
- R11: A write to any port without a write function (anything other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C, 0x0850, 0x0398, 0x0399) pulses bad_wr_err for one cycle and changes no stored field.
- R12: Ports 0x0398 and 0x0399 are two independent 8-bit read/write scratch registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| soft_rst_req | output | 1 | One-cycle soft reset request |
| endian_err | output | 1 | One-cycle unsupported byte-order request |
| nv_lock1_tgl | output | 1 | One-cycle lock 1 toggle |
| nv_lock2_tgl | output | 1 | One-cycle lock 2 toggle |
| cache_inval | output | 1 | One-cycle cache invalidate request |
| bad_wr_err | output | 1 | One-cycle strobe for a write to a port without a write function |
| map_noncontig | output | 1 | Stored I/O map mode |
| drive_led | output | 1 | Drive-activity indicator |

## Verification
The case that is hardest to reach from the ports is a write to a port that reads back but has no write function, such as 0x0818, 0x080C or 0x0823. The bench must show that the error strobe fires and that no stored field changes. To do this, the stimulus first loads non-zero values into the control nibble, the map bit and the indicator. It then makes the bad writes and reads every stored field back. A second subtle case is port 0x0810, which reads as an identification constant but pulses a lock toggle on write. The bench covers it by writing the port and then reading it.

// File: rtl/plat_ctl_pkg.sv
package plat_ctl_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int CTRL_W  = 4;
    localparam int SCR_N   = 2;
    localparam int SCR_IW  = (SCR_N > 1) ? $clog2(SCR_N) : 1;

    localparam logic [ADDR_W-1:0] P_SPECIAL = 16'h0092;
    localparam logic [ADDR_W-1:0] P_CPUCFG  = 16'h0800;
    localparam logic [ADDR_W-1:0] P_FEAT    = 16'h0802;
    localparam logic [ADDR_W-1:0] P_STAT    = 16'h0803;
    localparam logic [ADDR_W-1:0] P_LED     = 16'h0808;
    localparam logic [ADDR_W-1:0] P_EQUIP   = 16'h080C;
    localparam logic [ADDR_W-1:0] P_LOCK1   = 16'h0810;
    localparam logic [ADDR_W-1:0] P_LOCK2   = 16'h0812;
    localparam logic [ADDR_W-1:0] P_INVAL   = 16'h0814;
    localparam logic [ADDR_W-1:0] P_KEY     = 16'h0818;
    localparam logic [ADDR_W-1:0] P_CTRL    = 16'h081C;
    localparam logic [ADDR_W-1:0] P_L2STAT  = 16'h0823;
    localparam logic [ADDR_W-1:0] P_MAP     = 16'h0850;
    localparam logic [ADDR_W-1:0] P_SCRATCH = 16'h0398;

    localparam logic [DATA_W-1:0] V_CPUCFG  = 8'hEF;
    localparam logic [DATA_W-1:0] V_FEAT    = 8'hAD;
    localparam logic [DATA_W-1:0] V_STAT    = 8'hE0;
    localparam logic [DATA_W-1:0] V_EQUIP   = 8'h3C;
    localparam logic [DATA_W-1:0] V_EXTFEAT = 8'h39;
    localparam logic [DATA_W-1:0] V_KEY     = 8'h00;
    localparam logic [DATA_W-1:0] V_L2STAT  = 8'h03;
    localparam logic [DATA_W-1:0] V_SPECIAL = 8'h00;
    localparam logic [DATA_W-1:0] V_FLOAT   = 8'hFF;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LED,
        SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_INVAL, SEL_KEY, SEL_CTRL,
        SEL_L2STAT, SEL_MAP, SEL_SCR
    } port_sel_e;

    typedef struct packed {
        logic [CTRL_W-1:0]           ctrl;
        logic                        map;
        logic                        led;
        logic [SCR_N-1:0][DATA_W-1:0] scr;
    } hold_t;

    typedef struct packed {
        logic rst_p;
        logic end_p;
        logic lk1_p;
        logic lk2_p;
        logic inv_p;
        logic bad_p;
    } pulse_t;

endpackage

// File: rtl/plat_ctl_decode.sv
module plat_ctl_decode
    import plat_ctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel,
    output logic [SCR_IW-1:0] scr_idx
);
    logic [SCR_N-1:0] scr_hit;

    generate
        for (genvar g = 0; g < SCR_N; g++) begin : g_scr
            assign scr_hit[g] = (addr == P_SCRATCH + ADDR_W'(g));
        end
    endgenerate

    always_comb begin
        scr_idx = '0;
        for (int i = 0; i < SCR_N; i++) begin
            if (scr_hit[i]) scr_idx = SCR_IW'(i);
        end
    end

    always_comb begin
        unique case (addr)
            P_SPECIAL: sel = SEL_SPECIAL;
            P_CPUCFG:  sel = SEL_CPUCFG;
            P_FEAT:    sel = SEL_FEAT;
            P_STAT:    sel = SEL_STAT;
            P_LED:     sel = SEL_LED;
            P_EQUIP:   sel = SEL_EQUIP;
            P_LOCK1:   sel = SEL_LOCK1;
            P_LOCK2:   sel = SEL_LOCK2;
            P_INVAL:   sel = SEL_INVAL;
            P_KEY:     sel = SEL_KEY;
            P_CTRL:    sel = SEL_CTRL;
            P_L2STAT:  sel = SEL_L2STAT;
            P_MAP:     sel = SEL_MAP;
            default:   sel = (|scr_hit) ? SEL_SCR : SEL_NONE;
        endcase
    end
endmodule

// File: rtl/plat_ctl_store.sv
module plat_ctl_store
    import plat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  port_sel_e         sel,
    input  logic [SCR_IW-1:0] scr_idx,
    input  logic [DATA_W-1:0] wdata,
    output hold_t             hold,
    output pulse_t            pulse
);
    hold_t  hold_d, hold_q;
    pulse_t pulse_d, pulse_q;

    always_comb begin
        hold_d  = hold_q;
        pulse_d = '0;
        if (wr) begin
            unique case (sel)
                SEL_SPECIAL: begin
                    pulse_d.rst_p = wdata[0];
                    pulse_d.end_p = wdata[1];
                end
                SEL_CPUCFG, SEL_FEAT, SEL_STAT: ;
                SEL_LED:   hold_d.led  = wdata[0];
                SEL_LOCK1: pulse_d.lk1_p = 1'b1;
                SEL_LOCK2: pulse_d.lk2_p = 1'b1;
                SEL_INVAL: pulse_d.inv_p = 1'b1;
                SEL_CTRL:  hold_d.ctrl = wdata[CTRL_W-1:0];
                SEL_MAP:   hold_d.map  = wdata[0];
                SEL_SCR:   hold_d.scr[scr_idx] = wdata;
                default:   pulse_d.bad_p = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            pulse_q <= '0;
        end else begin
            hold_q  <= hold_d;
            pulse_q <= pulse_d;
        end
    end

    assign hold  = hold_q;
    assign pulse = pulse_q;
endmodule

// File: rtl/plat_ctl_rdmux.sv
module plat_ctl_rdmux
    import plat_ctl_pkg::*;
(
    input  port_sel_e         sel,
    input  logic [SCR_IW-1:0] scr_idx,
    input  hold_t             hold,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        unique case (sel)
            SEL_SPECIAL: value = V_SPECIAL;
            SEL_CPUCFG:  value = V_CPUCFG;
            SEL_FEAT:    value = V_FEAT;
            SEL_STAT:    value = V_STAT;
            SEL_EQUIP:   value = V_EQUIP;
            SEL_LOCK1:   value = V_EXTFEAT;
            SEL_KEY:     value = V_KEY;
            SEL_L2STAT:  value = V_L2STAT;
            SEL_CTRL:    value = DATA_W'(hold.ctrl);
            SEL_MAP:     value = DATA_W'(hold.map);
            SEL_SCR:     value = hold.scr[scr_idx];
            default:     value = V_FLOAT;
        endcase
    end
endmodule

// File: rtl/plat_ctl_regs.sv
module plat_ctl_regs
    import plat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              soft_rst_req,
    output logic              endian_err,
    output logic              nv_lock1_tgl,
    output logic              nv_lock2_tgl,
    output logic              cache_inval,
    output logic              bad_wr_err,
    output logic              map_noncontig,
    output logic              drive_led
);
    port_sel_e         sel;
    logic [SCR_IW-1:0] scr_idx;
    hold_t             hold;
    pulse_t            pulse;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    plat_ctl_decode u_decode (
        .addr    (io_addr),
        .sel     (sel),
        .scr_idx (scr_idx)
    );

    plat_ctl_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (io_wr),
        .sel     (sel),
        .scr_idx (scr_idx),
        .wdata   (io_wdata),
        .hold    (hold),
        .pulse   (pulse)
    );

    plat_ctl_rdmux u_rdmux (
        .sel     (sel),
        .scr_idx (scr_idx),
        .hold    (hold),
        .value   (rd_value)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (io_rd) rdata_d = rd_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign io_rdata      = rdata_q;
    assign soft_rst_req  = pulse.rst_p;
    assign endian_err    = pulse.end_p;
    assign nv_lock1_tgl  = pulse.lk1_p;
    assign nv_lock2_tgl  = pulse.lk2_p;
    assign cache_inval   = pulse.inv_p;
    assign bad_wr_err    = pulse.bad_p;
    assign map_noncontig = hold.map;
    assign drive_led     = hold.led;
endmodule

// File: rtl/plat_ctl_chk.sv
module plat_ctl_chk
    import plat_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              soft_rst_req,
    input logic              endian_err,
    input logic              nv_lock1_tgl,
    input logic              nv_lock2_tgl,
    input logic              cache_inval,
    input logic              bad_wr_err,
    input logic              map_noncontig,
    input logic              drive_led
);
    // R2: read data holds when no read was sampled
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_rd) && $past(rst_n) |-> $stable(io_rdata));

    // R3: soft reset request only follows a qualifying write
    a_r3_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(io_wr && io_addr == 16'h0092 && io_wdata[0]));

    // R6: a write to lock 1 port always yields a toggle
    a_r6_lock1: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 16'h0810 |=> nv_lock1_tgl);

    // R6: lock 2 toggle only follows a write to its port
    a_r6_lock2_cause: assert property (@(posedge clk) disable iff (!rst_n)
        nv_lock2_tgl |-> $past(io_wr && io_addr == 16'h0812));

    // R8: map bit changes only through its own port
    a_r8_map_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && map_noncontig != $past(map_noncontig)
            |-> $past(io_wr && io_addr == 16'h0850));

    // R11: a rejected write leaves stored levels untouched
    a_r11_bad_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_err && $past(rst_n) |-> $stable(map_noncontig) && $stable(drive_led));

    // R9: invalidate only follows a write to its port
    a_r9_inval_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inval |-> $past(io_wr && io_addr == 16'h0814));
endmodule

bind plat_ctl_regs plat_ctl_chk u_chk (.*);

// File: tb/plat_ctl_regs_bench.sv
`timescale 1ns/1ps
module plat_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic soft_rst_req, endian_err, nv_lock1_tgl, nv_lock2_tgl;
    logic cache_inval, bad_wr_err, map_noncontig, drive_led;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] exp; string tag; logic [15:0] addr; } rd_item_t;
    rd_item_t exp_q[$];
    logic rd_pend = 1'b0;

    always #4 clk = ~clk;

    plat_ctl_regs u_plat_ctl_regs (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against queued expectations
    always @(posedge clk) rd_pend <= io_rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            rd_item_t it;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: actual 0x%0h expected none", "R2", io_rdata);
            end else begin
                it = exp_q.pop_front();
                chk(32'(io_rdata), 32'(it.exp), it.tag);
            end
        end
    end

    task automatic do_read(input logic [15:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag; it.addr = a;
        exp_q.push_back(it);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // write, then check every pulse output in the cycle after and the one after that
    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            input logic [5:0] exp_p, input string tag);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        chk(32'({soft_rst_req, endian_err, nv_lock1_tgl, nv_lock2_tgl, cache_inval, bad_wr_err}),
            32'(exp_p), tag);
        @(negedge clk);
        chk(32'({soft_rst_req, endian_err, nv_lock1_tgl, nv_lock2_tgl, cache_inval, bad_wr_err}),
            32'd0, {tag, " pulse end"});
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(32'(io_rdata), 0, "R1 rdata");
        chk(32'({soft_rst_req, endian_err, nv_lock1_tgl, nv_lock2_tgl, cache_inval,
                 bad_wr_err, map_noncontig, drive_led}), 0, "R1 outputs");
        do_read(16'h081C, 8'h00, "R1 ctrl");
        do_read(16'h0398, 8'h00, "R1 scr0");
        do_read(16'h0399, 8'h00, "R1 scr1");
        do_read(16'h0850, 8'h00, "R1 map");
        // R4 identification
        do_read(16'h0800, 8'hEF, "R4 0800");
        do_read(16'h0802, 8'hAD, "R4 0802");
        do_read(16'h0803, 8'hE0, "R4 0803");
        do_read(16'h080C, 8'h3C, "R4 080C");
        do_read(16'h0810, 8'h39, "R4 0810");
        do_write(16'h0800, 8'h55, 6'b000000, "R4 write 0800 ignored");
        do_write(16'h0803, 8'h00, 6'b000000, "R4 write 0803 ignored");
        do_read(16'h0800, 8'hEF, "R4 0800 after write");
        // R3 special port
        do_read(16'h0092, 8'h00, "R3 read");
        do_write(16'h0092, 8'h01, 6'b100000, "R3 soft reset");
        do_write(16'h0092, 8'h02, 6'b010000, "R3 endian");
        do_write(16'h0092, 8'h03, 6'b110000, "R3 both");
        do_write(16'h0092, 8'hFC, 6'b000000, "R3 none");
        // R5 indicator
        do_write(16'h0808, 8'hFF, 6'b000000, "R5 set");
        chk(32'(drive_led), 1, "R5 led on");
        do_write(16'h0808, 8'hFE, 6'b000000, "R5 clear");
        chk(32'(drive_led), 0, "R5 led off");
        do_write(16'h0808, 8'h01, 6'b000000, "R5 set again");
        // R6 locks
        do_write(16'h0810, 8'h00, 6'b001000, "R6 lock1");
        do_write(16'h0812, 8'hA5, 6'b000100, "R6 lock2");
        do_read(16'h0810, 8'h39, "R6 0810 reads id");
        // R7 control nibble
        do_write(16'h081C, 8'hAB, 6'b000000, "R7 write");
        do_read(16'h081C, 8'h0B, "R7 readback");
        // R8 map bit
        do_write(16'h0850, 8'hFF, 6'b000000, "R8 write");
        chk(32'(map_noncontig), 1, "R8 map out");
        do_read(16'h0850, 8'h01, "R8 readback");
        // R9 misc ports
        do_read(16'h0818, 8'h00, "R9 0818");
        do_read(16'h0823, 8'h03, "R9 0823");
        do_read(16'h0814, 8'hFF, "R9 0814 read");
        do_write(16'h0814, 8'h00, 6'b000010, "R9 invalidate");
        // R10 undecoded reads
        do_read(16'h1234, 8'hFF, "R10 1234");
        do_read(16'h0801, 8'hFF, "R10 0801");
        do_read(16'h039A, 8'hFF, "R10 039A");
        // R11 bad writes
        do_write(16'h0818, 8'h00, 6'b000001, "R11 0818");
        do_write(16'h080C, 8'h00, 6'b000001, "R11 080C");
        do_write(16'h0823, 8'h00, 6'b000001, "R11 0823");
        do_write(16'h4850, 8'h00, 6'b000001, "R11 4850");
        chk(32'({map_noncontig, drive_led}), 32'b11, "R11 levels kept");
        do_read(16'h081C, 8'h0B, "R11 ctrl kept");
        do_read(16'h0850, 8'h01, "R11 map kept");
        // R12 scratch
        do_write(16'h0398, 8'h5A, 6'b000000, "R12 w0");
        do_write(16'h0399, 8'hC3, 6'b000000, "R12 w1");
        do_read(16'h0398, 8'h5A, "R12 r0");
        do_read(16'h0399, 8'hC3, "R12 r1");
        // R2 hold with no read
        io_addr = 16'h0800;
        repeat (3) @(negedge clk);
        chk(32'(io_rdata), 32'hC3, "R2 hold");
        @(negedge clk);
        chk(32'(exp_q.size()), 0, "R2 queue drained");
        finish_run();
    end
endmodule